// File: doc/BRIEF.md
# Manchester Receive Decoder

This block turns a serial Manchester-coded line into a recovered data bit, a recovered bit clock and a one-cycle strobe per data bit. A system clock much faster than the bit rate oversamples the line through a two-stage synchroniser. Every transition in the middle of a bit restarts a timer of three quarters of a bit period. While that timer runs, other line edges have no effect. When it expires, the line is sampled, and that level is the first-half value of the following bit. Because the decoder realigns on every bit, drift between transmitter and receiver does not build up over a frame.

The line idles high. A frame is a start bit, then `DATA_BITS` data bits with the first received bit first, then a stop bit. The start bit's mid-bit falling edge aligns the decoder, so the first data bit is not lost. The recovered clock and the strobe are held off for the start and stop positions. If no mid-bit transition arrives within one and a half bit periods after a sample, the decoder returns to idle and waits for a new start bit. The bit period is an input in system clocks, and a select input chooses between the two usual polarity conventions.

Top module: `mrx_dec`

## Requirements
- R1: While reset is asserted and immediately after it, `data_o`, `rclk_o` and `valid_o` are all 0.
- R2: The line idles high. A frame begins with a falling edge of the synchronised line in the middle of a start bit (high first half, low second half). It ends with a stop bit (low first half, high second half). With `ieee_i`=0 each data bit's value equals the line level in its first half, so 1 is sent high-then-low and 0 is sent low-then-high.
- R3: With `ieee_i`=1 each decoded bit is the complement of its first-half line level. Start and stop framing on the line is unchanged.
- R4: `valid_o` is a one-cycle pulse with the decoded bit on `data_o`, given exactly `DATA_BITS` times per frame, in the order the bits are received. No strobe is given for the start or stop positions, and `data_o` changes only together with `valid_o`.
- R5: Each sample is taken (3*P)/4 system clocks after the detected mid-bit transition, where P is `bit_period_i`. `valid_o` therefore follows the preceding rise of `rclk_o` by exactly that many cycles. Edges at bit boundaries inside that window are ignored, so line periods within ±1/8 of P still decode correctly.
- R6: `rclk_o` rises at the mid-bit transition of each data bit and falls at the following sample. It rises exactly `DATA_BITS` times per frame and not for the start or stop bit. `data_o` is held stable at every rising edge of `rclk_o`.
- R7: If no mid-bit transition follows a sample within (3*P)/2 clocks, the decoder returns to idle. Rising line edges in idle are ignored, and the next complete frame decodes correctly.
- R8: The bit period is taken from `bit_period_i` at run time, with no change to the parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the line |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw Manchester line, asynchronous to `clk_i` |
| ieee_i | input | 1 | Polarity select: 0 means first-half level is the bit, 1 means it is inverted |
| bit_period_i | input | PERIOD_W | Bit period in system clocks (at least 4) |
| data_o | output | 1 | Last decoded data bit |
| rclk_o | output | 1 | Recovered bit clock; `data_o` is stable at its rising edge |
| valid_o | output | 1 | One-cycle strobe marking a newly decoded data bit |

## Verification
The bench builds the decoder with `DATA_BITS`=8 and `PERIOD_W`=8, so whole frames are short and many of them fit in one run. It programs bit periods of 16 and 24 clocks. At 16 it also drives line periods of 14 and 18 clocks, which puts boundary edges inside the sampling window and moves the sample close to both edges of the tolerance. All-zero and all-one bytes and a frame cut short after three bits exercise the ignored boundary edges, the phantom sample that follows a cut-off frame, and the return to idle on timeout.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
    // Decoder phases: waiting for a start bit, timing the sampling window,
    // waiting for the next mid-bit transition.
    typedef enum logic [1:0] {
        MRX_IDLE = 2'd0,
        MRX_WIN  = 2'd1,
        MRX_WAIT = 2'd2
    } mrx_state_e;
endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/mrx_span.sv
// One-shot span counter: done_o pulses LIMIT cycles after start_i.
module mrx_span #(
    parameter int W = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         clear_i,
    input  logic [W-1:0] limit_i,
    output logic         done_o
);
    typedef struct packed {
        logic         busy;
        logic [W-1:0] cnt;
    } span_t;

    span_t s_d, s_q;

    always_comb begin
        done_o = s_q.busy && (s_q.cnt == limit_i);
        s_d    = s_q;
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = W'(1);
        end else if (clear_i || done_o) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (s_q.busy) begin
            s_d.cnt  = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{busy: 1'b0, cnt: '0};
        else         s_q <= s_d;
    end
endmodule

// File: rtl/mrx_dec.sv
module mrx_dec #(
    parameter int DATA_BITS   = 8,
    parameter int PERIOD_W    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                line_i,
    input  logic                ieee_i,
    input  logic [PERIOD_W-1:0] bit_period_i,
    output logic                data_o,
    output logic                rclk_o,
    output logic                valid_o
);
    import mrx_pkg::*;

    localparam int IDX_W = $clog2(DATA_BITS + 2);
    localparam int LIM_W = PERIOD_W + 1;
    localparam int P3_W  = PERIOD_W + 2;
    localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(DATA_BITS);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(DATA_BITS + 1);

    typedef struct packed {
        mrx_state_e       st;
        logic             held;   // first-half level of the bit in progress
        logic             prev;   // synchronised line one cycle earlier
        logic [IDX_W-1:0] idx;    // samples taken in this frame
        logic             data;
        logic             rclk;
        logic             valid;
    } dec_t;

    dec_t r_d, r_q;

    logic ln;
    logic win_start, win_done;
    logic tmo_start, tmo_clear, tmo_done;
    logic [P3_W-1:0]  p3;
    logic [LIM_W-1:0] win_lim, tmo_lim;

    mrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (line_i),
        .q_o   (ln)
    );

    // Window = 3P/4, timeout = 3P/2, both from 3P.
    always_comb begin
        p3      = ({2'b00, bit_period_i} << 1) + {2'b00, bit_period_i};
        win_lim = {1'b0, p3[P3_W-1:2]};
        tmo_lim = p3[P3_W-1:1];
    end

    mrx_span #(.W(LIM_W)) win_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(win_start),
        .clear_i(1'b0),
        .limit_i(win_lim),
        .done_o (win_done)
    );

    mrx_span #(.W(LIM_W)) tmo_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(tmo_start),
        .clear_i(tmo_clear),
        .limit_i(tmo_lim),
        .done_o (tmo_done)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.prev  = ln;
        win_start = 1'b0;
        tmo_start = 1'b0;
        tmo_clear = 1'b0;
        unique case (r_q.st)
            MRX_IDLE: begin
                r_d.held = 1'b1;
                r_d.idx  = '0;
                r_d.rclk = 1'b0;
                // mid-bit falling edge of the start bit
                if (r_q.prev && !ln) begin
                    r_d.st    = MRX_WIN;
                    win_start = 1'b1;
                end
            end
            MRX_WIN: begin
                if (win_done) begin
                    if (r_q.idx == IDX_END) begin
                        // window after the stop transition: frame complete
                        r_d.st   = MRX_IDLE;
                        r_d.held = 1'b1;
                        r_d.idx  = '0;
                    end else begin
                        r_d.st    = MRX_WAIT;
                        r_d.held  = ln;
                        r_d.idx   = r_q.idx + 1'b1;
                        r_d.rclk  = 1'b0;
                        tmo_start = 1'b1;
                        if (r_q.idx < IDX_STOP) begin
                            r_d.data  = ln ^ ieee_i;
                            r_d.valid = 1'b1;
                        end
                    end
                end
            end
            MRX_WAIT: begin
                if (ln != r_q.held) begin
                    r_d.st    = MRX_WIN;
                    win_start = 1'b1;
                    tmo_clear = 1'b1;
                    r_d.rclk  = (r_q.idx != IDX_END);
                end else if (tmo_done) begin
                    r_d.st   = MRX_IDLE;
                    r_d.held = 1'b1;
                    r_d.idx  = '0;
                end
            end
            default: r_d.st = MRX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: MRX_IDLE, held: 1'b1, prev: 1'b1, idx: '0,
                     data: 1'b0, rclk: 1'b0, valid: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o  = r_q.data;
    assign rclk_o  = r_q.rclk;
    assign valid_o = r_q.valid;
endmodule

// File: rtl/mrx_dec_chk.sv
module mrx_dec_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic data_o,
    input logic rclk_o,
    input logic valid_o
);
    assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    assert_data_with_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(data_o) |-> valid_o);

    assert_strobe_clock_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> !rclk_o);

    assert_rise_data_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rclk_o) |-> $stable(data_o));

    assert_rise_not_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rclk_o) |-> !valid_o);
endmodule

bind mrx_dec mrx_dec_chk chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_o (data_o),
    .rclk_o (rclk_o),
    .valid_o(valid_o)
);

// File: tb/mrx_dec_tb.sv
module mrx_dec_tb_top;
    localparam int NB = 8;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_r = 1'b1;
    logic          ieee = 1'b0;
    logic [PW-1:0] per = 8'd16;
    logic          data_o, rclk_o, valid_o;

    mrx_dec #(.DATA_BITS(NB), .PERIOD_W(PW), .SYNC_STAGES(2)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .line_i      (line_r),
        .ieee_i      (ieee),
        .bit_period_i(per),
        .data_o      (data_o),
        .rclk_o      (rclk_o),
        .valid_o     (valid_o)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R2";
    logic  exp_q[$];
    int    rises = 0;
    int    cyc = 0;
    int    rise_cyc = 0;
    bit    pend = 0;
    logic  rclk_prev = 1'b0;
    logic  last_d = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            logic e;
            cyc++;
            if (rclk_o && !rclk_prev) begin
                rises++;
                chk(data_o == last_d, "R6 data stable at rclk rise", int'(data_o), int'(last_d));
                rise_cyc = cyc;
                pend = 1;
            end
            rclk_prev = rclk_o;
            if (valid_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 strobe with no expected bit", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(data_o == e, cur_req, int'(data_o), int'(e));
                end
                if (pend) begin
                    chk((cyc - rise_cyc) == (3 * int'(per)) / 4, "R5 sample delay after rclk rise",
                        cyc - rise_cyc, (3 * int'(per)) / 4);
                    pend = 0;
                end
                last_d = data_o;
            end
        end
    end

    task automatic half(input logic lvl, input int n);
        line_r = lvl;
        repeat (n) @(negedge clk);
    endtask

    // Drives start, nbits data bits (first bit first), optional stop and idle.
    task automatic send(input logic [NB-1:0] val, input int nbits, input int hp, input bit full);
        logic lvl;
        rises = 0;
        pend  = 0;
        half(1'b1, hp);
        half(1'b0, hp);
        for (int i = 0; i < nbits; i++) begin
            lvl = val[i] ^ ieee;
            exp_q.push_back(val[i]);
            half(lvl, hp);
            half(~lvl, hp);
        end
        if (full) begin
            half(1'b0, hp);
            half(1'b1, hp);
            half(1'b1, 4 * hp);
        end
    endtask

    task automatic full_frame(input logic [NB-1:0] val, input int hp, input string req);
        cur_req = req;
        send(val, NB, hp, 1'b1);
        chk(exp_q.size() == 0, "R4 all strobes seen, none for start/stop", exp_q.size(), 0);
        chk(rises == NB, "R6 rclk rises per frame", rises, NB);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(data_o == 1'b0 && rclk_o == 1'b0 && valid_o == 1'b0, "R1 outputs in reset",
            {data_o, rclk_o, valid_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(data_o == 1'b0 && rclk_o == 1'b0 && valid_o == 1'b0, "R1 outputs after reset",
            {data_o, rclk_o, valid_o}, 0);
        repeat (8) @(negedge clk);

        full_frame(8'h3C, 8, "R2 default polarity 0x3C");
        full_frame(8'h00, 8, "R2 all zero");
        full_frame(8'hFF, 8, "R2 all one");

        ieee = 1'b1;
        full_frame(8'hA5, 8, "R3 inverted polarity 0xA5");
        ieee = 1'b0;

        full_frame(8'h5A, 7, "R5 fast line period 14");
        full_frame(8'hC3, 9, "R5 slow line period 18");

        per = 8'd24;
        full_frame(8'h96, 12, "R8 bit period 24");
        per = 8'd16;
        repeat (4) @(negedge clk);

        // R7: frame cut after three bits (0,1,1); decoder samples one phantom
        // bit equal to the complement of the last one, then times out.
        cur_req = "R7 truncated frame";
        send(8'h06, 3, 8, 1'b0);
        exp_q.push_back(1'b0);
        half(1'b0, 48);
        half(1'b1, 32);
        chk(exp_q.size() == 0, "R7 truncated frame strobes", exp_q.size(), 0);
        chk(rises == 3, "R7 truncated frame rclk rises", rises, 3);
        full_frame(8'h81, 8, "R7 recovery frame");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule